// File: doc/BRIEF.md
# Two-Channel PWM Time-Base with Event Actions

This block produces two pulse-width-modulated outputs from one shared 16-bit time-base counter. The system clock is slowed by two prescalers in series: a coarse one that divides by a power of two and a fine one that divides by 1 or by an even number up to 14. The counter advances once per resulting tick. In count-up mode it runs from zero to a programmed period and then wraps to zero. Otherwise the counter is frozen.

Each output has its own compare value and its own pair of actions. One action fires when the counter is zero at a tick. The other fires when the counter equals the channel's compare value at a tick. An action can hold, clear, set or toggle its output. A typical setup uses "set at zero, toggle at compare", which gives a high time of compare ticks in every cycle of period+1 ticks. A shutdown setup uses "clear at zero, toggle at compare".

All settings are loaded through a single-cycle synchronous write port. Any write restarts the prescaler chain, so the timing after a write is deterministic.

Top module: `pwm_tbase_aq`

## Requirements
- R1: After reset both outputs are low, the counter reads 0, the period and compare values are 0, and the control word is 0x0003, which means frozen, divide by 1 and all actions hold.
- R2: The coarse code in control bits [4:2] divides the tick rate by 2 to the power of the code. With the fine code at 0 and coarse code 3, the counter first increments on the 8th clock edge after the control write.
- R3: The fine code in control bits [7:5] divides by 1 for code 0 and by twice the code otherwise. The total divide is the product of both ratios: coarse code 1 with fine code 7 gives a first increment on edge 28.
- R4: When control bits [1:0] are 00 (count-up), each tick moves the counter from the period value to 0 and from any other value v to v+1 modulo 2^16. One cycle therefore lasts period+1 ticks.
- R5: Any other value of control bits [1:0] freezes the counter and both outputs at their current values.
- R6: A period write (address 0) takes effect from the next tick, with no shadow stage.
- R7: A write to address 3 loads the counter. Any write on the port restarts the prescaler chain and suppresses the tick in that cycle, so the next tick comes a full divide later.
- R8: At a tick with the counter at 0, each output applies its zero action. Action codes are 00 hold, 01 low, 10 high and 11 toggle. Channel A's zero action is in control bits [9:8] and channel B's is in bits [13:12].
- R9: At a tick with the counter equal to a channel's compare value, that channel applies its compare action, using the same codes as R8. Compare A is at address 1 and its action in bits [11:10]. Compare B is at address 2 and its action in bits [15:14].
- R10: When the zero event and the compare event fall on the same tick, the zero action is applied first and the compare action second. With set and toggle this leaves the output low.
- R11: A compare value above the period never matches. With set-at-zero, that output stays high for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 3 | Register select: 0 period, 1 compare A, 2 compare B, 3 counter, 4 control; 5 to 7 select no register |
| wrData | input | 16 | Write data |
| outA | output | 1 | PWM output A |
| outB | output | 1 | PWM output B |
| cntVal | output | 16 | Current time-base counter value |

## Verification
The hardest case to reach is two events landing on the same tick, such as a zero event coinciding with a compare match. A close second is a write landing exactly where a tick would have fallen. Directed steps force the counter to 0 while the compare value is 0, and they rewrite the period on the tick where it becomes equal to the counter.

A long random phase then issues sparse writes of every kind, including writes to unused addresses. A cycle-accurate model in the bench tracks the prescaler phase, the counter and both outputs, and every cycle is compared against it. Random collisions between writes and ticks, counters above the period, and all sixteen action pairs are therefore checked as they happen.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

  localparam int NCH = 2;

  localparam int ADR_PER  = 0;
  localparam int ADR_CMPA = 1;
  localparam int ADR_CMPB = 2;
  localparam int ADR_CNT  = 3;
  localparam int ADR_CTRL = 4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } actE;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic wrPer;
    logic wrCmpA;
    logic wrCmpB;
    logic wrCnt;
  } strobeT;

  typedef struct packed {
    actE zeroAct;
    actE cmpAct;
  } chanCfgT;

  function automatic logic applyAct(input logic cur, input actE act);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/pwm_tbase_ctrl.sv
module pwm_tbase_ctrl
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 3,
  parameter int HS_W   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  output strobeT                strb,
  output chanCfgT [NCH-1:0]     cfg
);

  localparam int ACT_LSB = 2 + PRE_W + HS_W;
  localparam int CTRL_W  = ACT_LSB + 4 * NCH;
  localparam int CR_W    = 1 << PRE_W;
  localparam int HR_W    = HS_W + 1;

  logic [CTRL_W-1:0] ctrlReg;
  logic              run;
  logic [CR_W-1:0]   coarseRatio, coarseCnt;
  logic [HS_W-1:0]   hsCode;
  logic [HR_W-1:0]   hsRatio, hsCnt;
  logic              coarseLast, hsLast;

  // control word register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_W'(3);
    end else if (wrEn && wrAddr == ADDR_W'(ADR_CTRL)) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  assign run         = (ctrlReg[1:0] == 2'b00);
  assign coarseRatio = CR_W'(1) << ctrlReg[2 +: PRE_W];
  assign hsCode      = ctrlReg[2+PRE_W +: HS_W];
  assign hsRatio     = (hsCode == '0) ? HR_W'(1) : {hsCode, 1'b0};
  assign coarseLast  = (coarseCnt == coarseRatio - CR_W'(1));
  assign hsLast      = (hsCnt == hsRatio - HR_W'(1));

  // cascaded prescalers, restarted by any write or while frozen
  always_ff @(posedge clk) begin
    if (!rstN || wrEn || !run) begin
      coarseCnt <= '0;
      hsCnt     <= '0;
    end else if (coarseLast) begin
      coarseCnt <= '0;
      hsCnt     <= hsLast ? '0 : hsCnt + HR_W'(1);
    end else begin
      coarseCnt <= coarseCnt + CR_W'(1);
    end
  end

  always_comb begin
    strb        = '0;
    strb.tick   = run && !wrEn && coarseLast && hsLast;
    strb.wrPer  = wrEn && (wrAddr == ADDR_W'(ADR_PER));
    strb.wrCmpA = wrEn && (wrAddr == ADDR_W'(ADR_CMPA));
    strb.wrCmpB = wrEn && (wrAddr == ADDR_W'(ADR_CMPB));
    strb.wrCnt  = wrEn && (wrAddr == ADDR_W'(ADR_CNT));
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cfg
    assign cfg[ch].zeroAct = actE'(ctrlReg[ACT_LSB + 4*ch +: 2]);
    assign cfg[ch].cmpAct  = actE'(ctrlReg[ACT_LSB + 4*ch + 2 +: 2]);
  end

  // R7: a write restarts the coarse stage
  p_pre_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (coarseCnt == '0 && hsCnt == '0));

  // R3: fine stage advances once per completed coarse period
  p_hs_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (run && !wrEn && coarseLast && !hsLast) |=> (hsCnt == $past(hsCnt) + HR_W'(1)));

  // R5: frozen prescaler stays at its start
  p_frozen_pre_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !wrEn) |=> (coarseCnt == '0));

endmodule

// File: rtl/pwm_tbase_dp.sv
module pwm_tbase_dp
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  chanCfgT [NCH-1:0] cfg,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  cnt,
  output logic [NCH-1:0]    pwmOut
);

  logic [CNT_W-1:0] per;
  logic [NCH-1:0]   wrCmp;
  logic             zeroEv;

  assign wrCmp  = {strb.wrCmpB, strb.wrCmpA};
  assign zeroEv = strb.tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      per <= '0;
      cnt <= '0;
    end else begin
      if (strb.wrPer) per <= wrData;
      if (strb.wrCnt) begin
        cnt <= wrData;
      end else if (strb.tick) begin
        cnt <= (cnt == per) ? '0 : cnt + CNT_W'(1);
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CNT_W-1:0] cmpQ;
    logic             outQ, matchEv, afterZero, outNext;

    assign matchEv   = strb.tick && (cnt == cmpQ);
    assign afterZero = zeroEv  ? applyAct(outQ, cfg[ch].zeroAct) : outQ;
    assign outNext   = matchEv ? applyAct(afterZero, cfg[ch].cmpAct) : afterZero;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ <= '0;
        outQ <= 1'b0;
      end else begin
        if (wrCmp[ch]) cmpQ <= wrData;
        outQ <= outNext;
      end
    end

    assign pwmOut[ch] = outQ;

    // R8: set-at-zero with no coinciding match drives high
    p_zero_set_r8: assert property (@(posedge clk) disable iff (!rstN)
      (zeroEv && !matchEv && cfg[ch].zeroAct == ACT_HIGH) |=> outQ);

    // R10: set then toggle on one tick leaves the output low
    p_tie_order_r10: assert property (@(posedge clk) disable iff (!rstN)
      (zeroEv && matchEv && cfg[ch].zeroAct == ACT_HIGH && cfg[ch].cmpAct == ACT_TOGGLE)
      |=> !outQ);
  end

  // R4: wrap at the period
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.wrCnt && cnt == per) |=> (cnt == '0));

  // R4: step by one below the period
  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.wrCnt && cnt != per) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R5: no tick means counter and outputs hold
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.wrCnt) |=> ($stable(cnt) && $stable(pwmOut)));

  // R7: counter load
  p_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCnt |=> (cnt == $past(wrData)));

endmodule

// File: rtl/pwm_tbase_aq.sv
module pwm_tbase_aq
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 3,
  parameter int HS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              outA,
  output logic              outB,
  output logic [CNT_W-1:0]  cntVal
);

  strobeT            strb;
  chanCfgT [NCH-1:0] cfg;
  logic [NCH-1:0]    pwmOut;

  pwm_tbase_ctrl #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .HS_W(HS_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .strb(strb), .cfg(cfg)
  );

  pwm_tbase_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg),
    .wrData(wrData), .cnt(cntVal), .pwmOut(pwmOut)
  );

  assign outA = pwmOut[0];
  assign outB = pwmOut[1];

endmodule

// File: tb/pwm_tbase_aq_tb_top.sv
`timescale 1ns/1ps
module pwm_tbase_aq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        outA, outB;
  logic [15:0] cntVal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_tbase_aq dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .outA(outA), .outB(outB), .cntVal(cntVal)
  );

  // ---------------- reference model ----------------
  logic [15:0] mPer, mCa, mCb, mCnt, mCtrl;
  int          mPre;
  bit          mA, mB;

  function automatic int divOf(input logic [15:0] c);
    int hc = int'(c[7:5]);
    return (1 << c[4:2]) * ((hc == 0) ? 1 : 2 * hc);
  endfunction

  function automatic bit act(input bit cur, input logic [1:0] a);
    case (a)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [15:0] mk(input logic [1:0] mode, input int cc, input int hc,
                                     input logic [1:0] za, input logic [1:0] ca,
                                     input logic [1:0] zb, input logic [1:0] cb);
    logic [2:0] c3 = cc[2:0];
    logic [2:0] h3 = hc[2:0];
    return {cb, zb, ca, za, h3, c3, mode};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPer = 0; mCa = 0; mCb = 0; mCnt = 0; mCtrl = 16'h0003;
      mPre = 0; mA = 0; mB = 0;
    end else if (wrEn) begin
      case (wrAddr)
        3'd0: mPer  = wrData;
        3'd1: mCa   = wrData;
        3'd2: mCb   = wrData;
        3'd3: mCnt  = wrData;
        3'd4: mCtrl = wrData;
        default: ;
      endcase
      mPre = 0;
    end else if (mCtrl[1:0] == 2'b00) begin
      if (mPre == divOf(mCtrl) - 1) begin
        logic [15:0] old;
        old  = mCnt;
        mPre = 0;
        if (old == 0)   mA = act(mA, mCtrl[9:8]);
        if (old == mCa) mA = act(mA, mCtrl[11:10]);
        if (old == 0)   mB = act(mB, mCtrl[13:12]);
        if (old == mCb) mB = act(mB, mCtrl[15:14]);
        mCnt = (old == mPer) ? 16'd0 : old + 16'd1;
      end else begin
        mPre++;
      end
    end
  end

  // lockstep comparison (R4 R8 R9 R10 R11 across all stimulus)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (cntVal !== mCnt || outA !== mA || outB !== mB) begin
        errors++;
        if (errors < 20)
          $display("FAIL R4/R8/R9 lockstep: actual cnt=%0d A=%0b B=%0b expected cnt=%0d A=%0b B=%0b",
                   cntVal, outA, outB, mCnt, mA, mB);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] c0;
    bit a0, b0;
    void'($urandom(32'h00C0FFEE));
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    chk(outA == 0, "R1 outA", outA, 0);
    chk(outB == 0, "R1 outB", outB, 0);
    chk(cntVal == 0, "R1 counter", cntVal, 0);
    waitN(5);
    chk(cntVal == 0, "R1 frozen after reset", cntVal, 0);

    // R2 coarse divide 8
    wr(0, 16'd1000); wr(3, 0); wr(4, mk(2'b00, 3, 0, 0, 0, 0, 0));
    waitN(7); chk(cntVal == 0, "R2 before 8th edge", cntVal, 0);
    waitN(1); chk(cntVal == 1, "R2 at 8th edge", cntVal, 1);

    // R3 divide 2*14
    wr(3, 0); wr(4, mk(2'b00, 1, 7, 0, 0, 0, 0));
    waitN(27); chk(cntVal == 0, "R3 before 28th edge", cntVal, 0);
    waitN(1);  chk(cntVal == 1, "R3 at 28th edge", cntVal, 1);

    // R4 R8 R9 R11: set at zero, toggle at compare
    wr(0, 9); wr(1, 4); wr(2, 11); wr(3, 0);
    wr(4, mk(2'b00, 0, 0, 2'b10, 2'b11, 2'b10, 2'b11));
    waitN(1); chk(outA == 1, "R8 A set at zero", outA, 1);
    waitN(3); chk(outA == 1, "R9 A high before match", outA, 1);
    waitN(1); chk(outA == 0, "R9 A toggled at match", outA, 0);
    waitN(5); chk(cntVal == 0, "R4 wrap after period", cntVal, 0);
    waitN(1); chk(outA == 1 && cntVal == 1, "R4 new cycle A high", outA, 1);
    chk(outB == 1, "R11 B stays high, compare above period", outB, 1);

    // R10 compare 0 coincides with zero
    wr(1, 0); wr(3, 0);
    waitN(1); chk(outA == 0, "R10 set then toggle", outA, 0);
    chk(outB == 1, "R10 B unaffected", outB, 1);

    // R5 freeze
    wr(4, mk(2'b11, 0, 0, 2'b10, 2'b11, 2'b10, 2'b11));
    c0 = cntVal; a0 = outA; b0 = outB;
    waitN(50);
    chk(cntVal == c0, "R5 counter frozen", cntVal, c0);
    chk(outA == a0 && outB == b0, "R5 outputs frozen", {outA, outB}, {a0, b0});

    // R6 immediate period
    wr(3, 0); wr(0, 3); wr(4, mk(2'b00, 0, 0, 2'b10, 2'b11, 2'b10, 2'b11));
    waitN(4); chk(cntVal == 0, "R6 period 3 wraps", cntVal, 0);
    waitN(2); chk(cntVal == 2, "R6 counting", cntVal, 2);
    wr(0, 2);
    waitN(1); chk(cntVal == 0, "R6 new period used at once", cntVal, 0);

    // R8 clear-at-zero configuration
    wr(0, 9); wr(1, 4); wr(3, 0);
    wr(4, mk(2'b00, 0, 0, 2'b01, 2'b11, 2'b01, 2'b11));
    waitN(1); chk(outA == 0, "R8 A cleared at zero", outA, 0);
    waitN(4); chk(outA == 1, "R9 A toggles high at match", outA, 1);
    chk(outB == 0, "R8 B cleared, no match", outB, 0);

    // R7 counter load and prescaler restart
    wr(4, mk(2'b01, 0, 0, 0, 0, 0, 0)); wr(3, 16'h1234);
    chk(cntVal == 16'h1234, "R7 counter load", cntVal, 16'h1234);
    wr(3, 5); wr(4, mk(2'b00, 2, 0, 0, 0, 0, 0));
    waitN(2); wr(3, 7);
    waitN(3); chk(cntVal == 7, "R7 restart delays tick", cntVal, 7);
    waitN(1); chk(cntVal == 8, "R7 tick a full divide later", cntVal, 8);

    // constrained random phase
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 40 == 0) begin
        logic [2:0] a;
        logic [15:0] d;
        a = 3'($urandom % 8);
        case (a)
          3'd0:    d = 16'($urandom % 41);
          3'd1, 3'd2, 3'd3: d = 16'($urandom % 46);
          3'd4:    d = mk(($urandom % 5 == 0) ? 2'b11 : 2'b00, int'($urandom % 3),
                          int'($urandom % 4), 2'($urandom), 2'($urandom),
                          2'($urandom), 2'($urandom));
          default: d = 16'($urandom);
        endcase
        wr(a, d);
      end else begin
        waitN(1);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule